// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sorts every address issued on a CPU bus into one of four programmable windows: an internal-register window of fixed 4 KB, a PCI I/O window and two PCI memory windows. Software programs each PCI window through a low-decode field and a high-decode field, both counted in 2 MB granules, and places the internal-register window with a single 15-bit field. The block holds that configuration, turns it into begin and end addresses one clock after a write, moves window edges out of two fixed reserved address ranges, and answers each lookup with a one-hot hit vector and a translated target address.

Lookups travel as a stream. A request is accepted on a clock edge where `lk_valid` and `lk_ready` are both high, and its result appears on `res_*` one edge later. `lk_ready` is high whenever the result register is empty or the consumer takes its content in the same cycle (`res_ready`), so a stalled consumer holds the request side off without losing anything, and the result stays fixed until taken. The configuration port is a plain write/read port with no handshake: a write lands on the edge where `cfg_we` is high, and read data is combinational from `cfg_rsel`.

Top module: `addrwin_decoder`

## Requirements
- R1: A write to a PCI low field (select 0 = I/O, 2 = memory 0, 4 = memory 1) stores write-data bits 14:0 and also loads bits 10:0 into that window's remap field (read at select 7, 8, 9 for I/O, memory 0, memory 1).
- R2: A write to a PCI high field (select 1, 3, 5) keeps only write-data bits 6:0; the other bits read back as zero.
- R3: Writes to the remap selects 7 to 9 leave every field unchanged, and a read of any select above 9 returns zero.
- R4: On the clock after any configuration write, a PCI window takes up its new mapping only when bits 6:0 of its low field are no greater than its high field; otherwise its previous mapping stays in force.
- R5: A PCI window begins at the low field shifted left by 21 and spans (high + 1 - low[6:0]) granules of 2 MB; an address hits when it is at or above the begin and below the end.
- R6: The internal-register window (select 6, bits 14:0 kept) begins at its field placed on address bits 35:21, spans 4 KB, and translates a hit to the offset from its begin.
- R7: After reset the fields hold I/O low 0x080 and high 0x0F, memory 0 low 0x090 and high 0x1F, memory 1 low 0x790 and high 0x1F, internal 0x0A0, and each remap field equals its low field's bits 10:0.
- R8: A window end inside 0x1E000000-0x1F0FFFFF or 0x1FC00000-0x1FCFFFFF is pulled down to that range's start, a begin inside one is pushed up to the range's end, and a window left with end not above begin hits nothing.
- R9: An I/O hit returns the offset of the address from the window begin; a memory hit returns the address unchanged; a miss returns hit vector 0 and address 0.
- R10: The hit vector is one-hot or zero, with bit 0 internal, bit 1 I/O, bit 2 memory 0, bit 3 memory 1; where windows overlap, the lowest bit number wins.
- R11: A lookup accepted on the same edge as a configuration write is decoded with the mapping in force before that write.
- R12: A result appears one edge after acceptance; while `res_valid` is high and `res_ready` low, `lk_ready` is low and the result holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Field select for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 4 | Field select for reads |
| cfg_rdata | output | 32 | Read data for `cfg_rsel` |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_addr | input | 36 | CPU address to classify |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 4 | One-hot window hit |
| res_addr | output | 36 | Translated target address |

## Verification
The main function is tried with addresses at the first and last bytes of each window and one step beyond, which separates an inclusive begin from an exclusive end and shows offset against pass-through translation. Deliberately overlapped windows tell the priority order apart, and windows moved across the two reserved ranges show end clipping, begin clipping and a window clipped to nothing. A high field written below its low field shows that the old mapping survives, a write and a lookup on the same edge expose the update latency, and a stalled consumer shows that the result and the request side both hold.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
  // Window slots in the hit vector; lower index has priority.
  localparam int WIN_INT = 0;
  localparam int WIN_IO  = 1;
  localparam int WIN_M0  = 2;
  localparam int WIN_M1  = 3;
  localparam int NUM_WIN = 4;
  localparam int NUM_PCI = 3;

  // Configuration selects: PCI window w uses 2w (low), 2w+1 (high),
  // the internal window uses SEL_INT, remap fields follow at SEL_RMP0 + w.
  localparam int SEL_INT  = 6;
  localparam int SEL_RMP0 = 7;
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
  import addrwin_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int DW    = 32,
  parameter int LO_W  = 15,
  parameter int HI_W  = 7,
  parameter int RMP_W = 11,
  parameter logic [NUM_PCI*LO_W-1:0] LO_RST  = {15'h790, 15'h090, 15'h080},
  parameter logic [NUM_PCI*HI_W-1:0] HI_RST  = {7'h1F, 7'h1F, 7'h0F},
  parameter logic [LO_W-1:0]         INT_RST = 15'h0A0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [DW-1:0]                   cfg_wdata,
  input  logic [SEL_W-1:0]                cfg_rsel,
  output logic [DW-1:0]                   cfg_rdata,
  output logic [NUM_PCI-1:0][LO_W-1:0]    lo_o,
  output logic [NUM_PCI-1:0][HI_W-1:0]    hi_o,
  output logic [LO_W-1:0]                 int_o,
  output logic                            reload_o
);
  localparam logic [SEL_W-1:0] S_INT  = SEL_W'(SEL_INT);
  localparam logic [SEL_W-1:0] S_LAST = SEL_W'(SEL_RMP0 + NUM_PCI - 1);

  logic [NUM_PCI-1:0][RMP_W-1:0] rmp_q;
  logic [LO_W-1:0]               int_q;
  logic                          reload_q;

  for (genvar w = 0; w < NUM_PCI; w++) begin : g_win
    localparam logic [SEL_W-1:0] S_LO = SEL_W'(2 * w);
    localparam logic [SEL_W-1:0] S_HI = SEL_W'(2 * w + 1);
    localparam logic [LO_W-1:0]  LR   = LO_RST[w*LO_W +: LO_W];
    localparam logic [HI_W-1:0]  HR   = HI_RST[w*HI_W +: HI_W];

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q     <= LR;
        hi_q     <= HR;
        rmp_q[w] <= LR[RMP_W-1:0];
      end else if (cfg_we) begin
        if (cfg_sel == S_LO) begin
          lo_q     <= cfg_wdata[LO_W-1:0];
          rmp_q[w] <= cfg_wdata[RMP_W-1:0];
        end
        if (cfg_sel == S_HI) hi_q <= cfg_wdata[HI_W-1:0];
      end
    end

    assign lo_o[w] = lo_q;
    assign hi_o[w] = hi_q;

    assert_hi_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == S_HI) |=> (hi_q == $past(cfg_wdata[HI_W-1:0])));
    assert_remap_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == S_LO) |=> (rmp_q[w] == lo_q[RMP_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q    <= INT_RST;
      reload_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == S_INT) int_q <= cfg_wdata[LO_W-1:0];
      reload_q <= cfg_we && (cfg_sel <= S_INT);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_PCI; w++) begin
      if (cfg_rsel == SEL_W'(2 * w))        cfg_rdata = DW'(lo_o[w]);
      if (cfg_rsel == SEL_W'(2 * w + 1))    cfg_rdata = DW'(hi_o[w]);
      if (cfg_rsel == SEL_W'(SEL_RMP0 + w)) cfg_rdata = DW'(rmp_q[w]);
    end
    if (cfg_rsel == S_INT) cfg_rdata = DW'(int_q);
    if (cfg_rsel > S_LAST) cfg_rdata = '0;
  end

  assign int_o    = int_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/addrwin_map.sv
module addrwin_map #(
  parameter int               AW         = 36,
  parameter int               LO_W       = 15,
  parameter int               HI_W       = 7,
  parameter int               GRAN_SH    = 21,
  parameter int               FIXED_SIZE = 0,
  parameter logic [LO_W-1:0]  LO_RST     = '0,
  parameter logic [HI_W-1:0]  HI_RST     = '0,
  parameter logic [AW-1:0]    RA_LO      = 36'h01E000000,
  parameter logic [AW-1:0]    RA_HI      = 36'h01F100000,
  parameter logic [AW-1:0]    RB_LO      = 36'h01FC00000,
  parameter logic [AW-1:0]    RB_HI      = 36'h01FD00000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  output logic [AW-1:0]   beg_o,
  output logic [AW-1:0]   end_o,
  output logic            en_o
);
  // Returns {enable, begin, end} after moving edges out of reserved ranges.
  function automatic logic [2*AW:0] clip_win(input logic [AW-1:0] b_in,
                                             input logic [AW-1:0] len);
    logic [AW-1:0] b;
    logic [AW-1:0] e;
    b = b_in;
    e = b_in + len;
    if (e >= RA_LO && e < RA_HI) e = RA_LO;
    if (b >= RA_LO && b < RA_HI) b = RA_HI;
    if (e >= RB_LO && e < RB_HI) e = RB_LO;
    if (b >= RB_LO && b < RB_HI) b = RB_HI;
    if (e >= RA_HI && b < RA_LO) e = RA_LO;
    if (e >= RB_HI && b < RB_LO) e = RB_LO;
    return {(e > b), b, e};
  endfunction

  function automatic logic [AW-1:0] win_len(input logic [LO_W-1:0] l,
                                            input logic [HI_W-1:0] h);
    logic [AW-1:0] g;
    if (FIXED_SIZE != 0) return AW'(FIXED_SIZE);
    g = AW'(h) + AW'(1) - AW'(l[HI_W-1:0]);
    return g << GRAN_SH;
  endfunction

  localparam logic [2*AW:0] RST_MAP =
    clip_win(AW'(LO_RST) << GRAN_SH, win_len(LO_RST, HI_RST));

  logic            fits;
  logic [2*AW:0]   cand;
  logic [AW-1:0]   b_q, e_q;
  logic            en_q;

  assign fits = (FIXED_SIZE != 0) || (lo[HI_W-1:0] <= hi);
  assign cand = clip_win(AW'(lo) << GRAN_SH, win_len(lo, hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_q, b_q, e_q} <= RST_MAP;
    end else if (reload && fits) begin
      {en_q, b_q, e_q} <= cand;
    end
  end

  assign beg_o = b_q;
  assign end_o = e_q;
  assign en_o  = en_q;

  if (FIXED_SIZE == 0) begin : g_keep
    assert_keep_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !fits) |=> ($stable(b_q) && $stable(e_q) && $stable(en_q)));
  end

  assert_clear_of_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !((b_q >= RA_LO && b_q < RA_HI) || (b_q >= RB_LO && b_q < RB_HI)));
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match #(
  parameter int                 AW       = 36,
  parameter int                 NW       = 4,
  parameter logic [NW-1:0]      OFS_MASK = 4'b0011
) (
  input  logic [AW-1:0]          addr,
  input  logic [NW-1:0][AW-1:0]  beg,
  input  logic [NW-1:0][AW-1:0]  fin,
  input  logic [NW-1:0]          en,
  output logic [NW-1:0]          hit,
  output logic [AW-1:0]          tgt
);
  logic [NW-1:0] raw;

  for (genvar w = 0; w < NW; w++) begin : g_cmp
    assign raw[w] = en[w] && (addr >= beg[w]) && (addr < fin[w]);
  end

  // Lowest index wins.
  assign hit = raw & ~(raw - NW'(1));

  always_comb begin
    tgt = '0;
    for (int w = 0; w < NW; w++) begin
      if (hit[w]) tgt = OFS_MASK[w] ? (addr - beg[w]) : addr;
    end
  end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
  import addrwin_pkg::*;
#(
  parameter int AW       = 36,
  parameter int DW       = 32,
  parameter int SEL_W    = 4,
  parameter int LO_W     = 15,
  parameter int HI_W     = 7,
  parameter int RMP_W    = 11,
  parameter int GRAN_SH  = 21,
  parameter int INT_SIZE = 4096,
  parameter logic [NUM_PCI*LO_W-1:0] PCI_LO_RST = {15'h790, 15'h090, 15'h080},
  parameter logic [NUM_PCI*HI_W-1:0] PCI_HI_RST = {7'h1F, 7'h1F, 7'h0F},
  parameter logic [LO_W-1:0]         INT_RST    = 15'h0A0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [SEL_W-1:0] cfg_rsel,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [AW-1:0]    lk_addr,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [NUM_WIN-1:0] res_hit,
  output logic [AW-1:0]    res_addr
);
  logic [NUM_PCI-1:0][LO_W-1:0] lo_v;
  logic [NUM_PCI-1:0][HI_W-1:0] hi_v;
  logic [LO_W-1:0]              int_v;
  logic                         reload;

  logic [NUM_WIN-1:0][AW-1:0]   w_beg, w_end;
  logic [NUM_WIN-1:0]           w_en;
  logic [NUM_WIN-1:0]           m_hit;
  logic [AW-1:0]                m_tgt;

  addrwin_regs #(
    .SEL_W(SEL_W), .DW(DW), .LO_W(LO_W), .HI_W(HI_W), .RMP_W(RMP_W),
    .LO_RST(PCI_LO_RST), .HI_RST(PCI_HI_RST), .INT_RST(INT_RST)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .lo_o(lo_v), .hi_o(hi_v), .int_o(int_v), .reload_o(reload)
  );

  for (genvar w = 0; w < NUM_PCI; w++) begin : g_pci
    addrwin_map #(
      .AW(AW), .LO_W(LO_W), .HI_W(HI_W), .GRAN_SH(GRAN_SH), .FIXED_SIZE(0),
      .LO_RST(PCI_LO_RST[w*LO_W +: LO_W]), .HI_RST(PCI_HI_RST[w*HI_W +: HI_W])
    ) i_map (
      .clk(clk), .rst_n(rst_n), .reload(reload), .lo(lo_v[w]), .hi(hi_v[w]),
      .beg_o(w_beg[WIN_IO + w]), .end_o(w_end[WIN_IO + w]), .en_o(w_en[WIN_IO + w])
    );
  end

  addrwin_map #(
    .AW(AW), .LO_W(LO_W), .HI_W(HI_W), .GRAN_SH(GRAN_SH), .FIXED_SIZE(INT_SIZE),
    .LO_RST(INT_RST), .HI_RST('0)
  ) i_int_map (
    .clk(clk), .rst_n(rst_n), .reload(reload), .lo(int_v), .hi('0),
    .beg_o(w_beg[WIN_INT]), .end_o(w_end[WIN_INT]), .en_o(w_en[WIN_INT])
  );

  addrwin_match #(
    .AW(AW), .NW(NUM_WIN),
    .OFS_MASK(NUM_WIN'((1 << WIN_INT) | (1 << WIN_IO)))
  ) i_match (
    .addr(lk_addr), .beg(w_beg), .fin(w_end), .en(w_en),
    .hit(m_hit), .tgt(m_tgt)
  );

  // Single result register with pass-through ready.
  logic take;
  assign lk_ready = !res_valid || res_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= '0;
      res_addr  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_hit   <= m_hit;
      res_addr  <= m_tgt;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_onehot_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_hit));
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit == '0) |-> (res_addr == '0));
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_addr)));
  assert_stall_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !lk_ready);
endmodule

// File: tb/test_addrwin_decoder.sv
`timescale 1ns/1ps
module test_addrwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_rsel = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [35:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [3:0]  res_hit;
  logic [35:0] res_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addrwin_decoder i_addrwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_addr(res_addr)
  );

  typedef struct packed {
    logic [35:0] a;
    logic [3:0]  h;
    logic [35:0] t;
  } vec_t;

  // Reset mapping: hit bit 0 internal, 1 I/O, 2 memory 0, 3 memory 1.
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{36'h010000000, 4'b0010, 36'h000000000},
    '{36'h011FFFFFF, 4'b0010, 36'h001FFFFFF},
    '{36'h012000000, 4'b0100, 36'h012000000},
    '{36'h013FFFFFC, 4'b0100, 36'h013FFFFFC},
    '{36'h014000000, 4'b0001, 36'h000000000},
    '{36'h014000FFC, 4'b0001, 36'h000000FFC},
    '{36'h014001000, 4'b0000, 36'h000000000},
    '{36'h0F2000000, 4'b1000, 36'h0F2000000},
    '{36'h0F3FFFFFF, 4'b1000, 36'h0F3FFFFFF},
    '{36'h0F4000000, 4'b0000, 36'h000000000},
    '{36'h00FFFFFFF, 4'b0000, 36'h000000000},
    '{36'h8F2000000, 4'b0000, 36'h000000000}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] sel, input logic [31:0] exp);
    @(negedge clk);
    cfg_rsel = sel;
    #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(input string req, input logic [35:0] a,
                      input logic [3:0] eh, input logic [35:0] et);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, 64'(res_valid), 64'(1));
    chk({req, " hit"},   64'(res_hit),   64'(eh));
    chk({req, " addr"},  64'(res_addr),  64'(et));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    chk("R7 res_valid", 64'(res_valid), 64'(0));
    chk("R12 lk_ready idle", 64'(lk_ready), 64'(1));
    rd("R7 io lo", 4'd0, 32'h080);
    rd("R7 io hi", 4'd1, 32'h0F);
    rd("R7 m0 lo", 4'd2, 32'h090);
    rd("R7 m0 hi", 4'd3, 32'h1F);
    rd("R7 m1 lo", 4'd4, 32'h790);
    rd("R7 m1 hi", 4'd5, 32'h1F);
    rd("R7 int",   4'd6, 32'h0A0);
    rd("R7 io remap", 4'd7, 32'h080);
    rd("R7 m0 remap", 4'd8, 32'h090);
    rd("R7 m1 remap", 4'd9, 32'h790);

    // R5 R6 R9 R10 reset mapping table
    for (int i = 0; i < NV; i++) begin
      look($sformatf("R5 R6 R9 vector %0d", i), VT[i].a, VT[i].h, VT[i].t);
    end

    // R1 low write keeps 14:0, remap gets 10:0, window moves
    wr(4'd4, 32'h0001_7A90);
    rd("R1 m1 lo", 4'd4, 32'h7A90);
    rd("R1 m1 remap", 4'd9, 32'h290);
    look("R1 R5 m1 moved", 36'hF52000000, 4'b1000, 36'hF52000000);
    look("R1 R5 m1 old gone", 36'h0F2000000, 4'b0000, 36'h0);

    // R2 high write masking
    wr(4'd1, 32'hFFFF_FF8F);
    rd("R2 io hi", 4'd1, 32'h0F);

    // R3 remap selects are read-only, unknown select reads zero
    wr(4'd7, 32'h0000_0555);
    rd("R3 io remap kept", 4'd7, 32'h080);
    rd("R3 io lo kept", 4'd0, 32'h080);
    rd("R3 unknown select", 4'd12, 32'h0);

    // R4 high below low keeps the previous mapping
    wr(4'd3, 32'h05);
    rd("R4 m0 hi stored", 4'd3, 32'h05);
    look("R4 m0 kept", 36'h013FFFFFC, 4'b0100, 36'h013FFFFFC);
    wr(4'd3, 32'h1F);

    // R10 priority on overlap
    wr(4'd6, 32'h090);
    look("R10 int over m0", 36'h012000800, 4'b0001, 36'h800);
    wr(4'd4, 32'h090);
    look("R10 m0 over m1", 36'h012100000, 4'b0100, 36'h012100000);
    wr(4'd1, 32'h1F);
    wr(4'd0, 32'h090);
    look("R10 R9 io over m0", 36'h012100000, 4'b0010, 36'h100000);
    look("R10 int over io", 36'h012000010, 4'b0001, 36'h10);

    // R8 end clipped at first reserved range
    wr(4'd1, 32'h70);
    wr(4'd0, 32'h0EF);
    look("R8 io below clip", 36'h01DFFFFFC, 4'b0010, 36'h1FFFFC);
    look("R8 io end clipped", 36'h01E000000, 4'b0000, 36'h0);
    // R8 begin pushed past first reserved range
    wr(4'd3, 32'h79);
    wr(4'd2, 32'h0F8);
    look("R8 m0 begin clipped", 36'h01F000000, 4'b0000, 36'h0);
    look("R8 m0 new begin", 36'h01F100000, 4'b0100, 36'h01F100000);
    // R8 internal window inside second range vanishes
    wr(4'd6, 32'h0FE);
    look("R8 int removed", 36'h01FC00000, 4'b0000, 36'h0);
    look("R8 int removed above", 36'h01FD00000, 4'b0000, 36'h0);

    // R11 lookup on the write edge uses the old mapping
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd6; cfg_wdata = 32'h0A0;
    lk_valid = 1'b1; lk_addr = 36'h014000000;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    chk("R11 same-edge hit", 64'(res_hit), 64'(0));
    look("R11 after update", 36'h014000004, 4'b0001, 36'h4);

    // R12 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = 36'h01F100000;
    @(negedge clk);
    lk_addr = 36'h01E000000;
    chk("R12 first result", 64'(res_hit), 64'(4'b0100));
    chk("R12 ready low", 64'(lk_ready), 64'(0));
    repeat (2) @(negedge clk);
    chk("R12 held addr", 64'(res_addr), 64'(36'h01F100000));
    chk("R12 held valid", 64'(res_valid), 64'(1));
    chk("R12 still blocked", 64'(lk_ready), 64'(0));
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R12 second valid", 64'(res_valid), 64'(1));
    chk("R12 second hit", 64'(res_hit), 64'(0));
    chk("R9 second addr", 64'(res_addr), 64'(0));
    @(negedge clk);
    chk("R12 drained", 64'(res_valid), 64'(0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule